// File: doc/BRIEF.md
# Set/Clear GPIO Pad Controller

A register-mapped controller for 64 general-purpose pins on a plain 32-bit word bus. The bus has a word address, a write strobe, write data and combinational read data. Each pin owns an output latch, a direction bit, a 2-bit function code, a pull-up enable, a pull-up select, a hysteresis enable and a keeper enable. The controller drives these straight to the pad-side control outputs.

Every per-pin field of one bit sits in a pair of 32-bit words. The lower word of the pair carries pins 0 to 31 and the upper word carries pins 32 to 63. Firmware can write a whole word into the output latches or into the direction bits. It can also use write-only alias words that raise or lower only the bits written as 1, so no read-modify-write is needed.

The function code chooses what drives each pad output: the pin's own latch or the pin's primary peripheral signal. A read of the data word returns, bit by bit, either the output latch or the pad input after a two-flop synchronizer.

Top module: `gpio_pad_ctrl`

Word map (word address, low word first in each pair):

| Words | Field |
|-------|-------|
| 0, 1 | output latch, plain write |
| 2, 3 | direction, plain write |
| 4, 5 | latch set alias |
| 6, 7 | latch clear alias |
| 8, 9 | direction set alias |
| 10, 11 | direction clear alias |
| 12 to 15 | function code, 16 pins per word |
| 16, 17 | data-read select |
| 18, 19 | pull-up enable |
| 20, 21 | pull-up select |
| 22, 23 | hysteresis enable |
| 24, 25 | keeper enable |
| 26 to 31 | unmapped |

## Requirements
- R1: After reset every register is 0 except the function codes, which are 3 for every pin. All pins are therefore GPIO inputs: pad_oe_o is 0 and pad_func_o is all ones.
- R2: A write to word 0 (pins 0 to 31) or word 1 (pins 32 to 63) replaces all 32 latch bits of that half at once. A cycle with no write leaves every register unchanged.
- R3: A write to latch set word 4 (low) or 5 (high) sets each latch bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: A write to latch clear word 6 (low) or 7 (high) clears each latch bit whose write-data bit is 1. Bits written as 0 keep their value.
- R5: Direction words 2 and 3 take plain writes. Words 8 and 9 set direction bits and words 10 and 11 clear them, in the same way as R3 and R4. A direction bit of 1 drives pad_oe_o high for that pin.
- R6: The alias words 4 to 11 and the unmapped words 26 to 31 always read as 0. Writes to unmapped words change nothing.
- R7: Pin p has its function code in word 12 + p/16, at bits [2*(p%16)+1 : 2*(p%16)]. pad_func_o[2p+1:2p] mirrors that code.
- R8: For each pin, pad_out_o is the output latch when the code is 3, alt_out_i when the code is 1, and 0 when the code is 0 or 2.
- R9: A data-word read returns the latch for pins whose data-read select bit (words 16/17) is 1. For the other pins it returns pad_in_i after two flops: a pad change shows on rdata_o after the second rising edge, and not after the first.
- R10: Pull-up enable (18/19), pull-up select (20/21), hysteresis (22/23) and keeper (24/25) read back what was written and drive pad_pu_en_o, pad_pu_sel_o, pad_hyst_o and pad_keep_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | 5 | Bus word address |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Bus read data, combinational from addr_i |
| pad_in_i | input | 64 | Pad input values, asynchronous |
| alt_out_i | input | 64 | Primary peripheral output per pin |
| pad_out_o | output | 64 | Pad output value |
| pad_oe_o | output | 64 | Pad output enable |
| pad_pu_en_o | output | 64 | Pull-up enable |
| pad_pu_sel_o | output | 64 | Pull-up select |
| pad_hyst_o | output | 64 | Hysteresis enable |
| pad_keep_o | output | 64 | Keeper enable |
| pad_func_o | output | 128 | Function code, 2 bits per pin |

## Verification
A wrong latch or direction bit shows on pad_out_o or pad_oe_o one cycle after the write that caused it. It also shows at once on a data or direction read with the read select set. Each alias write is followed by a readback of the whole word, so a bit that is disturbed without being addressed is caught before the next stimulus. A fault in the synchronizer depth shows as pad data on rdata_o one edge too early or too late. A fault in the function multiplexer shows on pad_out_o when alt_out_i is toggled with the function codes held.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  // register groups; group g occupies words g*WORDS .. g*WORDS+WORDS-1
  localparam int G_DATA  = 0;
  localparam int G_DIR   = 1;
  localparam int G_DSET  = 2;
  localparam int G_DCLR  = 3;
  localparam int G_RSET  = 4;
  localparam int G_RCLR  = 5;
  localparam int G_FUNC0 = 6;  // function codes take two groups
  localparam int G_FUNC1 = 7;
  localparam int G_DSEL  = 8;
  localparam int G_PUEN  = 9;
  localparam int G_PUSEL = 10;
  localparam int G_HYST  = 11;
  localparam int G_KEEP  = 12;

  typedef logic [1:0] fsel_t;
  localparam fsel_t FSEL_ALT  = 2'd1;
  localparam fsel_t FSEL_GPIO = 2'd3;
endpackage

// File: rtl/gpio_bit_bank.sv
module gpio_bit_bank #(
  parameter int NUM_PINS = 64,
  parameter int DW       = 32,
  localparam int WORDS   = NUM_PINS / DW
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [WORDS-1:0]    wr_i,
  input  logic [WORDS-1:0]    set_i,
  input  logic [WORDS-1:0]    clr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [NUM_PINS-1:0] q_o
);
  logic [NUM_PINS-1:0] q;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q[w*DW +: DW] <= '0;
      else if (wr_i[w])  q[w*DW +: DW] <= wdata_i;
      else if (set_i[w]) q[w*DW +: DW] <= q[w*DW +: DW] | wdata_i;
      else if (clr_i[w]) q[w*DW +: DW] <= q[w*DW +: DW] & ~wdata_i;
    end
  end

  assign q_o = q;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|{wr_i, set_i, clr_i}) |=> $stable(q_o)); // R2
  AST_SET_ONLY_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i && !(|wr_i)) |=> ((q_o & $past(q_o)) == $past(q_o))); // R3
  AST_CLR_ONLY_LOWERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i && !(|wr_i)) |=> ((q_o | $past(q_o)) == $past(q_o))); // R4
endmodule

// File: rtl/gpio_func_bank.sv
module gpio_func_bank #(
  parameter int NUM_PINS = 64,
  parameter int DW       = 32,
  localparam int PPW     = DW / 2,
  localparam int FWORDS  = NUM_PINS / PPW
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [FWORDS-1:0]     wr_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [2*NUM_PINS-1:0] func_o
);
  for (genvar f = 0; f < FWORDS; f++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      func_o[f*DW +: DW] <= '1;  // every pin starts as GPIO
      else if (wr_i[f]) func_o[f*DW +: DW] <= wdata_i;
    end
  end

  AST_FUNC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|wr_i) |=> $stable(func_o)); // R7
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta <= '0;
      q_o  <= '0;
    end else begin
      meta <= d_i;
      q_o  <= meta;
    end
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pad_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int DW       = 32,
  parameter int AW       = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [DW-1:0]         rdata_o,
  input  logic [NUM_PINS-1:0]   pad_in_i,
  input  logic [NUM_PINS-1:0]   alt_out_i,
  output logic [NUM_PINS-1:0]   pad_out_o,
  output logic [NUM_PINS-1:0]   pad_oe_o,
  output logic [NUM_PINS-1:0]   pad_pu_en_o,
  output logic [NUM_PINS-1:0]   pad_pu_sel_o,
  output logic [NUM_PINS-1:0]   pad_hyst_o,
  output logic [NUM_PINS-1:0]   pad_keep_o,
  output logic [2*NUM_PINS-1:0] pad_func_o
);
  localparam int WORDS  = NUM_PINS / DW;
  localparam int FWORDS = 2 * WORDS;

  function automatic logic hit(input int idx);
    return wr_en_i && (int'(addr_i) == idx);
  endfunction

  logic [WORDS-1:0]  wr_data, wr_dir, st_data, cl_data, st_dir, cl_dir;
  logic [WORDS-1:0]  wr_dsel, wr_puen, wr_pusel, wr_hyst, wr_keep;
  logic [FWORDS-1:0] wr_func;
  logic [WORDS-1:0]  zero_w;

  assign zero_w = '0;

  for (genvar w = 0; w < WORDS; w++) begin : g_dec
    assign wr_data[w]  = hit(G_DATA  * WORDS + w);
    assign wr_dir[w]   = hit(G_DIR   * WORDS + w);
    assign st_data[w]  = hit(G_DSET  * WORDS + w);
    assign cl_data[w]  = hit(G_DCLR  * WORDS + w);
    assign st_dir[w]   = hit(G_RSET  * WORDS + w);
    assign cl_dir[w]   = hit(G_RCLR  * WORDS + w);
    assign wr_dsel[w]  = hit(G_DSEL  * WORDS + w);
    assign wr_puen[w]  = hit(G_PUEN  * WORDS + w);
    assign wr_pusel[w] = hit(G_PUSEL * WORDS + w);
    assign wr_hyst[w]  = hit(G_HYST  * WORDS + w);
    assign wr_keep[w]  = hit(G_KEEP  * WORDS + w);
  end
  for (genvar f = 0; f < FWORDS; f++) begin : g_fdec
    assign wr_func[f] = hit(G_FUNC0 * WORDS + f);
  end

  logic [NUM_PINS-1:0] data_q, dir_q, dsel_q, pad_sync;

  gpio_bit_bank #(.NUM_PINS(NUM_PINS), .DW(DW)) u_data (
    .clk_i, .rst_ni, .wr_i(wr_data), .set_i(st_data), .clr_i(cl_data),
    .wdata_i, .q_o(data_q));
  gpio_bit_bank #(.NUM_PINS(NUM_PINS), .DW(DW)) u_dir (
    .clk_i, .rst_ni, .wr_i(wr_dir), .set_i(st_dir), .clr_i(cl_dir),
    .wdata_i, .q_o(dir_q));
  gpio_bit_bank #(.NUM_PINS(NUM_PINS), .DW(DW)) u_dsel (
    .clk_i, .rst_ni, .wr_i(wr_dsel), .set_i(zero_w), .clr_i(zero_w),
    .wdata_i, .q_o(dsel_q));
  gpio_bit_bank #(.NUM_PINS(NUM_PINS), .DW(DW)) u_puen (
    .clk_i, .rst_ni, .wr_i(wr_puen), .set_i(zero_w), .clr_i(zero_w),
    .wdata_i, .q_o(pad_pu_en_o));
  gpio_bit_bank #(.NUM_PINS(NUM_PINS), .DW(DW)) u_pusel (
    .clk_i, .rst_ni, .wr_i(wr_pusel), .set_i(zero_w), .clr_i(zero_w),
    .wdata_i, .q_o(pad_pu_sel_o));
  gpio_bit_bank #(.NUM_PINS(NUM_PINS), .DW(DW)) u_hyst (
    .clk_i, .rst_ni, .wr_i(wr_hyst), .set_i(zero_w), .clr_i(zero_w),
    .wdata_i, .q_o(pad_hyst_o));
  gpio_bit_bank #(.NUM_PINS(NUM_PINS), .DW(DW)) u_keep (
    .clk_i, .rst_ni, .wr_i(wr_keep), .set_i(zero_w), .clr_i(zero_w),
    .wdata_i, .q_o(pad_keep_o));

  gpio_func_bank #(.NUM_PINS(NUM_PINS), .DW(DW)) u_func (
    .clk_i, .rst_ni, .wr_i(wr_func), .wdata_i, .func_o(pad_func_o));

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(pad_sync));

  assign pad_oe_o = dir_q;

  // pad output multiplexer
  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      unique case (fsel_t'(pad_func_o[2*p +: 2]))
        FSEL_GPIO: pad_out_o[p] = data_q[p];
        FSEL_ALT:  pad_out_o[p] = alt_out_i[p];
        default:   pad_out_o[p] = 1'b0;
      endcase
    end
  end

  // read path
  logic [NUM_PINS-1:0] data_view;
  int rd_idx, rd_grp, rd_w;

  assign data_view = (dsel_q & data_q) | (~dsel_q & pad_sync);

  always_comb begin
    rd_idx  = int'(addr_i);
    rd_grp  = rd_idx / WORDS;
    rd_w    = rd_idx % WORDS;
    rdata_o = '0;
    case (rd_grp)
      G_DATA:           rdata_o = data_view[rd_w*DW +: DW];
      G_DIR:            rdata_o = dir_q[rd_w*DW +: DW];
      G_FUNC0, G_FUNC1: rdata_o = pad_func_o[(rd_idx - G_FUNC0*WORDS)*DW +: DW];
      G_DSEL:           rdata_o = dsel_q[rd_w*DW +: DW];
      G_PUEN:           rdata_o = pad_pu_en_o[rd_w*DW +: DW];
      G_PUSEL:          rdata_o = pad_pu_sel_o[rd_w*DW +: DW];
      G_HYST:           rdata_o = pad_hyst_o[rd_w*DW +: DW];
      G_KEEP:           rdata_o = pad_keep_o[rd_w*DW +: DW];
      default:          rdata_o = '0;
    endcase
  end

  AST_ALIAS_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(addr_i) >= G_DSET*WORDS && int'(addr_i) < G_FUNC0*WORDS) |-> rdata_o == '0); // R6
  AST_DIR_SET_DRIVES_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && int'(addr_i) == G_RSET*WORDS)
      |=> ((pad_oe_o[DW-1:0] & $past(wdata_i)) == $past(wdata_i))); // R5
endmodule

// File: tb/gpio_pad_ctrl_tb.sv
module gpio_pad_ctrl_tb;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en = 1'b0;
  logic [4:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [63:0]  pad_in = '0;
  logic [63:0]  alt_out = '0;
  logic [63:0]  pad_out, pad_oe, pu_en, pu_sel, hyst, keep;
  logic [127:0] func;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  gpio_pad_ctrl u_dut (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pad_in_i(pad_in), .alt_out_i(alt_out),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_pu_en_o(pu_en),
    .pad_pu_sel_o(pu_sel), .pad_hyst_o(hyst), .pad_keep_o(keep),
    .pad_func_o(func));

  typedef struct packed {
    logic        wr;
    logic [4:0]  addr;
    logic [31:0] data;  // write data, or expected read data
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 5'd16, 32'hFFFF_FFFF, 4'd9},
    '{1'b1, 5'd17, 32'hFFFF_FFFF, 4'd9},
    '{1'b1, 5'd0,  32'hA5A5_1234, 4'd2},  // R2 low half
    '{1'b0, 5'd0,  32'hA5A5_1234, 4'd2},
    '{1'b1, 5'd1,  32'h0F0F_0F0F, 4'd2},  // R2 high half
    '{1'b0, 5'd1,  32'h0F0F_0F0F, 4'd2},
    '{1'b1, 5'd4,  32'h0000_00C0, 4'd3},  // R3
    '{1'b0, 5'd0,  32'hA5A5_12F4, 4'd3},
    '{1'b1, 5'd5,  32'hF000_0000, 4'd3},
    '{1'b0, 5'd1,  32'hFF0F_0F0F, 4'd3},
    '{1'b1, 5'd6,  32'hA000_0004, 4'd4},  // R4
    '{1'b0, 5'd0,  32'h05A5_12F0, 4'd4},
    '{1'b1, 5'd7,  32'h0000_000F, 4'd4},
    '{1'b0, 5'd1,  32'hFF0F_0F00, 4'd4},
    '{1'b0, 5'd4,  32'h0000_0000, 4'd6},  // R6 alias reads zero
    '{1'b0, 5'd7,  32'h0000_0000, 4'd6},
    '{1'b1, 5'd8,  32'h0000_FFFF, 4'd5},  // R5
    '{1'b0, 5'd2,  32'h0000_FFFF, 4'd5},
    '{1'b1, 5'd10, 32'h0000_00FF, 4'd5},
    '{1'b0, 5'd2,  32'h0000_FF00, 4'd5},
    '{1'b1, 5'd3,  32'h1234_5678, 4'd5},
    '{1'b1, 5'd9,  32'h8000_0001, 4'd5},
    '{1'b0, 5'd3,  32'h9234_5679, 4'd5},
    '{1'b1, 5'd12, 32'h0000_0000, 4'd7},  // R7
    '{1'b1, 5'd15, 32'hE4E4_E4E4, 4'd7},
    '{1'b0, 5'd15, 32'hE4E4_E4E4, 4'd7},
    '{1'b0, 5'd13, 32'hFFFF_FFFF, 4'd7},
    '{1'b1, 5'd18, 32'hDEAD_BEEF, 4'd10}, // R10
    '{1'b1, 5'd25, 32'hCAFE_F00D, 4'd10},
    '{1'b0, 5'd25, 32'hCAFE_F00D, 4'd10}
  };

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, 128'(rdata), 128'(exp));
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1 reset state
    chk("R1 oe", 128'(pad_oe), 128'h0);
    chk("R1 func", func, {128{1'b1}});
    chk("R1 out", 128'(pad_out), 128'h0);
    rd_chk("R1 func word", 5'd12, 32'hFFFF_FFFF);
    rd_chk("R1 pull word", 5'd18, 32'h0);

    // R9 two-flop synchronized pad input (data-read select is 0 after reset)
    addr = 5'd1;
    @(negedge clk) pad_in = 64'h5A5A_0000_0000_0000;
    @(posedge clk); #1;
    chk("R9 one edge", 128'(rdata), 128'h0);
    @(posedge clk); #1;
    chk("R9 two edges", 128'(rdata), 128'h5A5A_0000);
    pad_in = '0;
    repeat (2) @(posedge clk);

    // table of vectors
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) bus_wr(VEC[i].addr, VEC[i].data);
      else rd_chk($sformatf("R%0d vec %0d", VEC[i].req, i), VEC[i].addr, VEC[i].data);
    end

    // R5 output enable follows direction
    chk("R5 oe", 128'(pad_oe), 128'h9234_5679_0000_FF00);
    // R7 function codes on the pad side
    chk("R7 func hi", 128'(func[127:96]), 128'hE4E4_E4E4);
    chk("R7 func lo", 128'(func[31:0]), 128'h0);
    // R10 pad control outputs
    chk("R10 pull en", 128'(pu_en[31:0]), 128'hDEAD_BEEF);
    chk("R10 keeper", 128'(keep[63:32]), 128'hCAFE_F00D);
    chk("R10 idle", 128'({pu_sel, hyst}), 128'h0);

    // R8 output multiplexer: codes 0 / 3 / 1,2 mix
    @(negedge clk) alt_out = '1;
    #1 chk("R8 alt high", 128'(pad_out), 128'hAA2A_0F00_05A5_0000);
    @(negedge clk) alt_out = '0;
    #1 chk("R8 alt low", 128'(pad_out), 128'h8808_0F00_05A5_0000);

    // R6 unmapped word: write ignored, reads zero
    bus_wr(5'd28, 32'hFFFF_FFFF);
    rd_chk("R6 unmapped", 5'd28, 32'h0);
    rd_chk("R6 data kept", 5'd0, 32'h05A5_12F0);

    // R9 latch view vs pad view per bit
    bus_wr(5'd16, 32'h0000_FFFF);
    @(negedge clk) pad_in = 64'h0000_0000_FFFF_0000;
    repeat (2) @(posedge clk);
    rd_chk("R9 mixed view", 5'd0, 32'hFFFF_12F0);

    summary();
  end
endmodule